// File: doc/BRIEF.md
# E1-to-T1 Rate Conversion Formatter

This block sits on the read side of a frame-organised elastic store and builds the serial stream sent to the system backplane. Every clock cycle is one backplane bit time. The block works out which bit of the current 256-bit E1 frame to fetch, places an address on `rd_addr`, and takes the selected bit back on `rd_bit` in the same cycle. At the last bit position of each output frame it pulses `rd_frame_adv`, which tells the store to move on to its next frame.

In 2.048 MHz mode the block reads the frame straight through, so all 32 timeslots appear in order. In 1.544 MHz mode each output frame is 193 bits long. It opens with a framing-bit position that is always driven high and then carries 24 channels of 8 bits. Every fourth E1 timeslot (0, 4, 8, ... 28) is never read. The remaining timeslots fill the 24 channels in ascending order.

Alongside the data, the block drives a frame pulse, a multiframe pulse and a general sync pulse. The multiframe pulse follows either the CAS alignment tag or the CRC4 alignment tag, which the store supplies with each frame. The general sync pulse follows either the frame pulse or the multiframe pulse. A channel-block output marks the bits of the channels selected by a 32-bit mask. All outputs are registered and lag `rd_addr` by one cycle.

Top module: `e1t1_fmt`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `fsync_out`, `msync_out`, `sync_out`, `chblk_out` and `rd_frame_adv` are all 0.
- R2: In 2.048 MHz mode (`rate_t1`=0) a frame has 256 bit positions. Output position p carries the store bit at address p of the current frame, so all 32 timeslots pass through unchanged.
- R3: In 1.544 MHz mode (`rate_t1`=1) position 0 of every frame is the framing bit, and `ser_out` is 1 there whatever the store holds.
- R4: In 1.544 MHz mode positions 1..192 carry channels 0..23, 8 bits each with the lowest address first. Channel k is read from the k-th timeslot, counting upward, among those whose number is not a multiple of 4. Timeslots 0, 4, 8, 12, 16, 20, 24 and 28 are never output.
- R5: `rd_frame_adv` is high for exactly one cycle, in the cycle when `rd_addr` serves the last position of the frame (position 255 in 2.048 MHz mode, position 192 in 1.544 MHz mode).
- R6: `fsync_out` is high for exactly one cycle per frame, in the cycle when position 0 appears on `ser_out`. This holds in both modes.
- R7: `msync_out` is high with `fsync_out` exactly when the frame's selected tag is set: `rd_crc_mf0` if `mf_crc4`=1, otherwise `rd_cas_mf0`.
- R8: `sync_out` equals `msync_out` when `sync_on_mf`=1 and equals `fsync_out` when `sync_on_mf`=0.
- R9: `chblk_out` is high on a bit that belongs to mask bit i (timeslot i in 2.048 MHz mode, channel i in 1.544 MHz mode) when `blk_mask[i]` is 1. It is low on the framing bit. In 1.544 MHz mode, mask bits 24..31 have no effect.
- R10: `rate_t1` is sampled at position 0 of each frame. A change in mid-frame only alters the length and layout of the next frame, so the spacing between `fsync_out` pulses is 256 or 193 cycles, according to the rate in force when the earlier frame began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_t1 | input | 1 | 1 = 1.544 MHz conversion, 0 = 2.048 MHz passthrough |
| sync_on_mf | input | 1 | 1 = sync_out follows multiframe pulse, 0 = frame pulse |
| mf_crc4 | input | 1 | 1 = CRC4 multiframe alignment, 0 = CAS alignment |
| blk_mask | input | 32 | Per-timeslot / per-channel block selection |
| rd_addr | output | 8 | Bit address within the current store frame |
| rd_frame_adv | output | 1 | Advance the store to its next frame |
| rd_bit | input | 1 | Store bit at rd_addr |
| rd_cas_mf0 | input | 1 | Current store frame opens a CAS multiframe |
| rd_crc_mf0 | input | 1 | Current store frame opens a CRC4 multiframe |
| ser_out | output | 1 | Serial backplane data |
| fsync_out | output | 1 | Frame boundary pulse |
| msync_out | output | 1 | Multiframe boundary pulse |
| sync_out | output | 1 | Selected frame or multiframe pulse |
| chblk_out | output | 1 | Channel-block timing |

## Verification
The bench builds the block with its default parameters: 32 timeslots of 8 bits, with every fourth timeslot dropped. At these values one frame is 256 or 193 cycles, so every bit position of more than 60 consecutive frames can be compared with an arithmetic model. The sweep covers both rates, both multiframe alignments (the CAS tag repeats every 16 frames from frame 0, the CRC4 tag every 16 frames from frame 5) and both sync sources. It also includes mid-frame rate changes and block masks that set only the unused channel bits 24..31.

// File: rtl/e1t1_fmt_pkg.sv
`timescale 1ns/1ps
package e1t1_fmt_pkg;

    typedef enum logic {
        RATE_E1 = 1'b0,
        RATE_T1 = 1'b1
    } rate_e;

endpackage

// File: rtl/e1t1_frame_timer.sv
`timescale 1ns/1ps
// Output bit-position counter; the rate is latched at position 0 of each frame.
module e1t1_frame_timer
    import e1t1_fmt_pkg::*;
#(
    parameter int E1_LEN = 256,
    parameter int T1_LEN = 193,
    parameter int POS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rate_e            rate_in,
    output logic [POS_W-1:0] pos,
    output rate_e            rate_now,
    output rate_e            rate_held,
    output logic             frame_last
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        rate_e            rate;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        rate_now = (tmr_q.pos == '0) ? rate_in : tmr_q.rate;
        if (rate_now == RATE_T1) begin
            frame_last = (tmr_q.pos == POS_W'(T1_LEN - 1));
        end else begin
            frame_last = (tmr_q.pos == POS_W'(E1_LEN - 1));
        end
        tmr_d.rate = rate_now;
        tmr_d.pos  = frame_last ? '0 : tmr_q.pos + POS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{pos: '0, rate: RATE_E1};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pos       = tmr_q.pos;
    assign rate_held = tmr_q.rate;

endmodule

// File: rtl/e1t1_slot_map.sv
`timescale 1ns/1ps
// Maps an output bit position to a store bit address and a block-mask index.
module e1t1_slot_map
    import e1t1_fmt_pkg::*;
#(
    parameter int TS_BITS     = 8,
    parameter int DROP_STRIDE = 4,
    parameter int POS_W       = 8,
    parameter int ADDR_W      = 8,
    parameter int CH_W        = 5
) (
    input  logic [POS_W-1:0]  pos,
    input  rate_e             rate,
    output logic [ADDR_W-1:0] addr,
    output logic              fbit,
    output logic [CH_W-1:0]   blk_idx
);

    localparam int KEEP = DROP_STRIDE - 1;

    always_comb begin
        int p;
        int ch;
        int bi;
        int ts;
        p = int'(pos);
        if (rate == RATE_T1) begin
            fbit = (p == 0);
            ch   = (p == 0) ? 0 : (p - 1) / TS_BITS;
            bi   = (p == 0) ? 0 : (p - 1) % TS_BITS;
            // skip the first slot of every group of DROP_STRIDE slots
            ts   = ch + ch / KEEP + 1;
        end else begin
            fbit = 1'b0;
            ch   = p / TS_BITS;
            bi   = p % TS_BITS;
            ts   = ch;
        end
        addr    = ADDR_W'(ts * TS_BITS + bi);
        blk_idx = CH_W'(ch);
    end

endmodule

// File: rtl/e1t1_fmt.sv
`timescale 1ns/1ps
module e1t1_fmt
    import e1t1_fmt_pkg::*;
#(
    parameter int NUM_TS      = 32,
    parameter int TS_BITS     = 8,
    parameter int DROP_STRIDE = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rate_t1,
    input  logic                              sync_on_mf,
    input  logic                              mf_crc4,
    input  logic [NUM_TS-1:0]                 blk_mask,
    output logic [$clog2(NUM_TS*TS_BITS)-1:0] rd_addr,
    output logic                              rd_frame_adv,
    input  logic                              rd_bit,
    input  logic                              rd_cas_mf0,
    input  logic                              rd_crc_mf0,
    output logic                              ser_out,
    output logic                              fsync_out,
    output logic                              msync_out,
    output logic                              sync_out,
    output logic                              chblk_out
);

    localparam int T1_CH  = NUM_TS - NUM_TS / DROP_STRIDE;
    localparam int E1_LEN = NUM_TS * TS_BITS;
    localparam int T1_LEN = T1_CH * TS_BITS + 1;
    localparam int POS_W  = $clog2(E1_LEN);
    localparam int ADDR_W = POS_W;
    localparam int CH_W   = $clog2(NUM_TS);

    rate_e             rate_now;
    rate_e             rate_held;
    logic [POS_W-1:0]  pos;
    logic              frame_last;
    logic              fbit;
    logic [CH_W-1:0]   blk_idx;
    logic              frame_t1;

    e1t1_frame_timer #(
        .E1_LEN (E1_LEN),
        .T1_LEN (T1_LEN),
        .POS_W  (POS_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_in    (rate_e'(rate_t1)),
        .pos        (pos),
        .rate_now   (rate_now),
        .rate_held  (rate_held),
        .frame_last (frame_last)
    );

    e1t1_slot_map #(
        .TS_BITS     (TS_BITS),
        .DROP_STRIDE (DROP_STRIDE),
        .POS_W       (POS_W),
        .ADDR_W      (ADDR_W),
        .CH_W        (CH_W)
    ) u_map (
        .pos     (pos),
        .rate    (rate_now),
        .addr    (rd_addr),
        .fbit    (fbit),
        .blk_idx (blk_idx)
    );

    assign rd_frame_adv = frame_last;
    assign frame_t1     = (rate_held == RATE_T1);

    typedef struct packed {
        logic ser;
        logic fsync;
        logic msync;
        logic sync;
        logic blk;
    } outs_t;

    outs_t outs_d, outs_q;

    always_comb begin
        outs_d.ser   = fbit ? 1'b1 : rd_bit;
        outs_d.fsync = (pos == '0);
        outs_d.msync = outs_d.fsync && (mf_crc4 ? rd_crc_mf0 : rd_cas_mf0);
        outs_d.sync  = sync_on_mf ? outs_d.msync : outs_d.fsync;
        outs_d.blk   = !fbit && blk_mask[blk_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outs_q <= '0;
        end else begin
            outs_q <= outs_d;
        end
    end

    assign ser_out   = outs_q.ser;
    assign fsync_out = outs_q.fsync;
    assign msync_out = outs_q.msync;
    assign sync_out  = outs_q.sync;
    assign chblk_out = outs_q.blk;

endmodule

// File: rtl/e1t1_fmt_chk.sv
`timescale 1ns/1ps
module e1t1_fmt_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_frame_adv,
    input logic ser_out,
    input logic fsync_out,
    input logic msync_out,
    input logic sync_out,
    input logic chblk_out,
    input logic frame_t1
);

    p_adv_to_fsync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_adv |=> ##1 fsync_out);

    p_adv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_adv |=> !rd_frame_adv);

    p_fsync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_out |=> !fsync_out);

    p_msync_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msync_out |-> fsync_out);

    p_sync_on_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> fsync_out);

    p_fbit_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_out && frame_t1) |-> ser_out);

    p_fbit_unblocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_out && frame_t1) |-> !chblk_out);

endmodule

bind e1t1_fmt e1t1_fmt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_frame_adv (rd_frame_adv),
    .ser_out      (ser_out),
    .fsync_out    (fsync_out),
    .msync_out    (msync_out),
    .sync_out     (sync_out),
    .chblk_out    (chblk_out),
    .frame_t1     (frame_t1)
);

// File: tb/e1t1_fmt_tb.sv
`timescale 1ns/1ps
module e1t1_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_t1 = 1'b0;
    logic        sync_on_mf = 1'b0;
    logic        mf_crc4 = 1'b0;
    logic [31:0] blk_mask = 32'hA5C3_0F11;
    logic [7:0]  rd_addr;
    logic        rd_frame_adv;
    logic        rd_bit;
    logic        rd_cas_mf0;
    logic        rd_crc_mf0;
    logic        ser_out, fsync_out, msync_out, sync_out, chblk_out;

    int total = 0;
    int bad = 0;
    int sframe;

    int epos = 0;
    int eframe = 0;
    logic fmode = 1'b0;
    int since = 0;
    int plen = 0;
    bit have_prev = 0;

    always #4 clk = ~clk;

    function automatic logic pat(int f, int a);
        int h;
        h = a * 37 + f * 11 + (a >> 3) * 5;
        return h[2] ^ h[5];
    endfunction

    function automatic int kept_ts(int k);
        int n;
        n = 0;
        for (int t = 0; t < 32; t++) begin
            if (t % 4 != 0) begin
                if (n == k) return t;
                n++;
            end
        end
        return -1;
    endfunction

    // elastic store model: frame counter advanced by the block
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) sframe <= 0;
        else if (rd_frame_adv) sframe <= sframe + 1;
    end
    assign rd_bit     = pat(sframe, int'(rd_addr));
    assign rd_cas_mf0 = (sframe % 16 == 0);
    assign rd_crc_mf0 = (sframe % 16 == 5);

    e1t1_fmt dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_t1      (rate_t1),
        .sync_on_mf   (sync_on_mf),
        .mf_crc4      (mf_crc4),
        .blk_mask     (blk_mask),
        .rd_addr      (rd_addr),
        .rd_frame_adv (rd_frame_adv),
        .rd_bit       (rd_bit),
        .rd_cas_mf0   (rd_cas_mf0),
        .rd_crc_mf0   (rd_crc_mf0),
        .ser_out      (ser_out),
        .fsync_out    (fsync_out),
        .msync_out    (msync_out),
        .sync_out     (sync_out),
        .chblk_out    (chblk_out)
    );

    task automatic chk(logic act, logic exp, string req, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (pos %0d frame %0d)",
                     req, what, act, exp, epos, eframe);
        end
    endtask

    task automatic check_cycle();
        logic eser, eblk, efs, ems, esy, eadv;
        int len, k;
        if (epos == 0) fmode = rate_t1;
        len = fmode ? 193 : 256;
        if (fmode) begin
            if (epos == 0) begin
                eser = 1'b1;
                eblk = 1'b0;
            end else begin
                k    = (epos - 1) / 8;
                eser = pat(eframe, kept_ts(k) * 8 + (epos - 1) % 8);
                eblk = blk_mask[k];
            end
        end else begin
            eser = pat(eframe, epos);
            eblk = blk_mask[epos / 8];
        end
        efs = (epos == 0);
        ems = efs && (mf_crc4 ? (eframe % 16 == 5) : (eframe % 16 == 0));
        esy = sync_on_mf ? ems : efs;

        if (fmode && epos == 0) chk(ser_out, eser, "R3", "framing bit");
        else if (fmode)         chk(ser_out, eser, "R4", "converted data");
        else                    chk(ser_out, eser, "R2", "passthrough data");
        chk(chblk_out, eblk, "R9", "channel block");
        chk(fsync_out, efs, "R6", "frame pulse");
        chk(msync_out, ems, "R7", "multiframe pulse");
        chk(sync_out, esy, "R8", "sync select");

        // frame spacing measured at the port (R10)
        if (fsync_out) begin
            if (have_prev) begin
                total++;
                if (since != plen) begin
                    bad++;
                    $display("FAIL R10 frame spacing: actual=%0d expected=%0d", since, plen);
                end
            end
            have_prev = 1;
            since = 0;
            plen = len;
        end
        since++;

        if (epos == len - 1) begin
            epos = 0;
            eframe++;
        end else begin
            epos++;
        end
        eadv = (epos != 0) && (epos == len - 1);
        chk(rd_frame_adv, eadv, "R5", "frame advance");
    endtask

    task automatic run(int nframes, logic n_rate, logic n_sel, logic n_crc, logic [31:0] n_mask);
        int start;
        bit applied;
        start = eframe;
        applied = 0;
        while (eframe < start + nframes) begin
            @(negedge clk);
            check_cycle();
            if (!applied && epos == 100) begin
                rate_t1    = n_rate;
                sync_on_mf = n_sel;
                mf_crc4    = n_crc;
                blk_mask   = n_mask;
                applied    = 1;
            end
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(ser_out, 1'b0, "R1", "reset ser");
            chk(fsync_out, 1'b0, "R1", "reset fsync");
            chk(msync_out, 1'b0, "R1", "reset msync");
            chk(sync_out, 1'b0, "R1", "reset sync");
            chk(chblk_out, 1'b0, "R1", "reset block");
            chk(rd_frame_adv, 1'b0, "R1", "reset advance");
        end
        rst_n = 1'b1;
        run(3,  1'b0, 1'b0, 1'b0, 32'hA5C3_0F11);
        run(18, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
        run(18, 1'b1, 1'b1, 1'b1, 32'hFF00_0000);
        run(18, 1'b0, 1'b1, 1'b1, 32'h0000_FFFF);
        run(4,  1'b1, 1'b0, 1'b0, 32'h1234_5678);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule